// File: doc/BRIEF.md
# Configurable-Way Cache Controller

This block is the lookup and fill controller of a small read/write cache whose associativity is chosen at run time. Its storage is a fixed set of tag and data subarrays, one pair per physical way. Software sets the number of active ways to any power of two from the full count down to one, which is direct-mapped. At lower associativity the address bits just above the base index select which group of subarrays a reference may use. The number of sets in use therefore grows as the ways shrink, total capacity stays the same, and a lookup powers only the subarrays of that group.

The controller remembers the block address and the way of the last access that hit. When the next reference falls in that same block, no tag subarray is enabled and only the one data subarray that holds the line is read or written. Hit, miss and data behaviour is the same as a conventional cache of the configured associativity. Writes go through to the next level and never allocate. Read misses fetch a whole line over a simple refill port. Two running counters report how many tag and data subarray enables were spent, so the savings can be measured.

Top module: `cwc_cache`

## Requirements
- R1: Reset puts the controller in its idle state: req_ready high while cfg_load is low, resp_valid and mem_valid low, both enable counters zero, no subarray enabled while no request is accepted, and all ways active.
- R2: A read miss raises mem_valid with mem_write low and mem_addr set to the line base (word offset bits zero). It waits for mem_ready, writes the returned line into the victim way, then pulses resp_valid for one cycle with resp_hit low and the requested word of mem_rline (word i at bits i*DATA_W upward).
- R3: A read hit pulses resp_valid in the cycle after acceptance, with resp_hit high and the stored word, and makes no memory request.
- R4: A lookup outside the shortcut enables exactly 2^m tag and 2^m data subarrays, where m is the configured log2 way count. These are subarrays p whose bits above the low m bits equal the address bits just above the base index, shifted left by m. Values of cfg_ways_log above log2(WAYS) select all ways.
- R5: When the accepted address lies in the block recorded by the last-access register and that register is valid, tag_en is all zero, data_en is one-hot on the way holding the line, and the access is a hit.
- R6: The last-access register is loaded by every read hit and write hit. It is cleared by every miss (read or write), by a configuration change and by reset, so the shortcut is never taken after these events.
- R7: Every write is forwarded to memory with mem_write high, its own word address and data, held stable until mem_ready. A write hit also updates the cached word; a write miss allocates nothing. resp_hit of a write reports whether it hit.
- R8: A read miss replaces a victim chosen by a per-set round-robin pointer. The pointer starts at 0 and advances by one modulo the active way count at every refill of that set. The victim is always inside the group enabled for the address.
- R9: cfg_load is taken only while idle; it then blocks request acceptance for that cycle, invalidates every line and resets all round-robin pointers. While a miss or write is outstanding cfg_load is ignored.
- R10: tag_en_cnt and data_en_cnt add the number of tag and data subarrays enabled by each accepted request.
- R11: In direct-mapped mode, lines whose addresses share the base index but differ in the group bits sit in different subarrays and are all kept at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Apply cfg_ways_log (honoured only when idle) |
| cfg_ways_log | input | MODE_W | log2 of the active way count |
| req_valid | input | 1 | CPU request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted this cycle when valid |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_hit | output | 1 | Access hit in the cache |
| resp_rdata | output | DATA_W | Read data |
| mem_valid | output | 1 | Memory request pending |
| mem_write | output | 1 | Pending request is a write-through |
| mem_addr | output | ADDR_W | Line base for refill, word address for write |
| mem_wdata | output | DATA_W | Write-through data |
| mem_ready | input | 1 | Memory completes the pending request |
| mem_rline | input | LINE_WORDS*DATA_W | Refill line, word 0 in the low bits |
| tag_en | output | WAYS | Tag subarray enables of the accepted lookup |
| data_en | output | WAYS | Data subarray enables of the accepted lookup |
| tag_en_cnt | output | CNT_W | Running total of tag enables |
| data_en_cnt | output | CNT_W | Running total of data enables |

## Verification
The bench builds the controller with its defaults: four ways, four rows per subarray, four-word lines and a 10-bit word address. With these, five conflicting lines overflow a set at full associativity and make the round-robin wrap visible. The two group bits sit directly above the base index, so two-way and direct-mapped modes can be reached by small hand-picked addresses. Each mode is checked against a behavioural model of subarrays, pointers and the last-access register. The model covers out-of-range configuration values and a configuration pulse during a pending refill.

// File: rtl/cwc_pkg.sv
package cwc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_REFILL = 2'd1,
    ST_WTHRU  = 2'd2
  } cwc_state_e;

endpackage

// File: rtl/cwc_grp_dec.sv
module cwc_grp_dec #(
  parameter int WAYS     = 4,
  parameter int LOG_WAYS = $clog2(WAYS),
  parameter int MODE_W   = $clog2(LOG_WAYS + 1)
) (
  input  logic [MODE_W-1:0]   mode,
  input  logic [LOG_WAYS-1:0] ext,
  output logic [WAYS-1:0]     grp_mask,
  output logic [LOG_WAYS-1:0] grp_base,
  output logic [LOG_WAYS-1:0] low_mask
);

  // low_mask selects the logical way bits, the rest name the group
  always_comb begin
    for (int b = 0; b < LOG_WAYS; b++) begin
      low_mask[b] = (MODE_W'(b) < mode);
    end
    grp_base = ext << mode;
  end

  for (genvar p = 0; p < WAYS; p++) begin : g_sel
    assign grp_mask[p] = ((LOG_WAYS'(p) & ~low_mask) == grp_base);
  end

endmodule

// File: rtl/cwc_subarray.sv
module cwc_subarray #(
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 4,
  parameter int TAG_W      = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         inval_all,
  input  logic                         tag_en,
  input  logic                         data_en,
  input  logic [$clog2(SETS)-1:0]      row,
  input  logic [$clog2(LINE_WORDS)-1:0] word,
  input  logic [TAG_W-1:0]             cmp_tag,
  input  logic                         wr_we,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         fill_we,
  input  logic [$clog2(SETS)-1:0]      fill_row,
  input  logic [TAG_W-1:0]             fill_tag,
  input  logic [LINE_WORDS*DATA_W-1:0] fill_line,
  output logic                         match,
  output logic [DATA_W-1:0]            rd_data
);

  logic [SETS-1:0]   vld_q, vld_d;
  logic              vld_ce;
  logic [TAG_W-1:0]  tag_q [SETS];
  logic [DATA_W-1:0] dat_q [SETS][LINE_WORDS];

  always_comb begin
    vld_d  = vld_q;
    vld_ce = inval_all | fill_we;
    if (inval_all) begin
      vld_d = '0;
    end else if (fill_we) begin
      vld_d[fill_row] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (vld_ce) begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_we) begin
      tag_q[fill_row] <= fill_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_we) begin
      for (int w = 0; w < LINE_WORDS; w++) begin
        dat_q[fill_row][w] <= fill_line[w*DATA_W +: DATA_W];
      end
    end else if (wr_we) begin
      dat_q[row][word] <= wr_data;
    end
  end

  // a disabled subarray neither compares nor drives data
  assign match   = tag_en & vld_q[row] & (tag_q[row] == cmp_tag);
  assign rd_data = data_en ? dat_q[row][word] : '0;

endmodule

// File: rtl/cwc_cache.sv
module cwc_cache
  import cwc_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int WAYS       = 4,
  parameter int SETS       = 4,
  parameter int CNT_W      = 32,
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int IDX_W     = $clog2(SETS),
  localparam int LOG_WAYS  = $clog2(WAYS),
  localparam int MODE_W    = $clog2(LOG_WAYS + 1),
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
  localparam int BLK_W     = ADDR_W - OFF_W,
  localparam int LINE_W    = LINE_WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [MODE_W-1:0] cfg_ways_log,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [LINE_W-1:0] mem_rline,
  output logic [WAYS-1:0]   tag_en,
  output logic [WAYS-1:0]   data_en,
  output logic [CNT_W-1:0]  tag_en_cnt,
  output logic [CNT_W-1:0]  data_en_cnt
);

  // ---------------- state ----------------
  cwc_state_e          state_q, state_d;
  logic [MODE_W-1:0]   mode_q, mode_d;
  logic                last_vld_q, last_vld_d;
  logic [BLK_W-1:0]    last_blk_q;
  logic [LOG_WAYS-1:0] last_way_q;
  logic                last_load;
  logic                rsp_vld_q, rsp_vld_d;
  logic                rsp_hit_q, rsp_hit_d;
  logic [DATA_W-1:0]   rsp_dat_q, rsp_dat_d;
  logic [CNT_W-1:0]    tcnt_q, tcnt_d, dcnt_q, dcnt_d;
  logic [LOG_WAYS-1:0] rr_q [SETS];
  logic [LOG_WAYS-1:0] rr_d [SETS];
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [LOG_WAYS-1:0] victim_q;
  logic                hitw_q;

  // ---------------- request decode ----------------
  logic                idle, cfg_apply, accept, shortcut;
  logic [IDX_W-1:0]    req_set, set_q;
  logic [OFF_W-1:0]    req_word, word_q;
  logic [TAG_W-1:0]    req_tag, tag_fill;
  logic [BLK_W-1:0]    req_blk;
  logic [LOG_WAYS-1:0] req_ext;
  logic [WAYS-1:0]     grp_mask, last_onehot;
  logic [LOG_WAYS-1:0] grp_base, low_mask, victim;
  logic [MODE_W-1:0]   cfg_clamped;

  assign req_set  = req_addr[OFF_W +: IDX_W];
  assign req_word = req_addr[OFF_W-1:0];
  assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign req_blk  = req_addr[ADDR_W-1:OFF_W];
  assign req_ext  = req_addr[OFF_W+IDX_W +: LOG_WAYS];
  assign set_q    = addr_q[OFF_W +: IDX_W];
  assign word_q   = addr_q[OFF_W-1:0];
  assign tag_fill = addr_q[ADDR_W-1 -: TAG_W];

  assign idle      = (state_q == ST_IDLE);
  assign cfg_apply = idle & cfg_load;
  assign accept    = idle & ~cfg_load & req_valid;
  assign req_ready = idle & ~cfg_load;
  assign shortcut  = last_vld_q & (req_blk == last_blk_q);
  assign last_onehot = WAYS'(1) << last_way_q;
  assign cfg_clamped = (cfg_ways_log > MODE_W'(LOG_WAYS)) ? MODE_W'(LOG_WAYS) : cfg_ways_log;

  cwc_grp_dec #(
    .WAYS     (WAYS),
    .LOG_WAYS (LOG_WAYS),
    .MODE_W   (MODE_W)
  ) u_dec (
    .mode     (mode_q),
    .ext      (req_ext),
    .grp_mask (grp_mask),
    .grp_base (grp_base),
    .low_mask (low_mask)
  );

  assign victim  = grp_base | (rr_q[req_set] & low_mask);
  assign tag_en  = (accept & ~shortcut) ? grp_mask : '0;
  assign data_en = accept ? (shortcut ? last_onehot : grp_mask) : '0;

  // ---------------- subarrays ----------------
  logic [WAYS-1:0]     match, wr_we, fill_we;
  logic [DATA_W-1:0]   sub_rd [WAYS];
  logic                hit;
  logic [LOG_WAYS-1:0] match_way, hit_way;

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    assign wr_we[g]   = accept & req_write & hit & (hit_way == LOG_WAYS'(g));
    assign fill_we[g] = (state_q == ST_REFILL) & mem_ready & (victim_q == LOG_WAYS'(g));

    cwc_subarray #(
      .DATA_W     (DATA_W),
      .LINE_WORDS (LINE_WORDS),
      .SETS       (SETS),
      .TAG_W      (TAG_W)
    ) u_sub (
      .clk       (clk),
      .rst_n     (rst_n),
      .inval_all (cfg_apply),
      .tag_en    (tag_en[g]),
      .data_en   (data_en[g]),
      .row       (req_set),
      .word      (req_word),
      .cmp_tag   (req_tag),
      .wr_we     (wr_we[g]),
      .wr_data   (req_wdata),
      .fill_we   (fill_we[g]),
      .fill_row  (set_q),
      .fill_tag  (tag_fill),
      .fill_line (mem_rline),
      .match     (match[g]),
      .rd_data   (sub_rd[g])
    );
  end

  always_comb begin
    match_way = '0;
    for (int p = 0; p < WAYS; p++) begin
      if (match[p]) begin
        match_way = LOG_WAYS'(p);
      end
    end
  end

  assign hit       = shortcut | (|match);
  assign hit_way   = shortcut ? last_way_q : match_way;
  assign last_load = accept & hit;

  // ---------------- next state ----------------
  always_comb begin
    state_d    = state_q;
    mode_d     = mode_q;
    last_vld_d = last_vld_q;
    rsp_vld_d  = 1'b0;
    rsp_hit_d  = rsp_hit_q;
    rsp_dat_d  = '0;
    tcnt_d     = tcnt_q;
    dcnt_d     = dcnt_q;
    rr_d       = rr_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cfg_apply) begin
          mode_d     = cfg_clamped;
          last_vld_d = 1'b0;
          for (int s = 0; s < SETS; s++) begin
            rr_d[s] = '0;
          end
        end else if (accept) begin
          tcnt_d     = tcnt_q + CNT_W'($countones(tag_en));
          dcnt_d     = dcnt_q + CNT_W'($countones(data_en));
          last_vld_d = hit;
          if (req_write) begin
            state_d = ST_WTHRU;
          end else if (hit) begin
            rsp_vld_d = 1'b1;
            rsp_hit_d = 1'b1;
            rsp_dat_d = sub_rd[hit_way];
          end else begin
            state_d = ST_REFILL;
          end
        end
      end
      ST_REFILL: begin
        if (mem_ready) begin
          state_d        = ST_IDLE;
          rsp_vld_d      = 1'b1;
          rsp_hit_d      = 1'b0;
          rsp_dat_d      = mem_rline[word_q*DATA_W +: DATA_W];
          last_vld_d     = 1'b0;
          rr_d[set_q]    = (victim_q + 1'b1) & low_mask;
        end
      end
      ST_WTHRU: begin
        if (mem_ready) begin
          state_d   = ST_IDLE;
          rsp_vld_d = 1'b1;
          rsp_hit_d = hitw_q;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      mode_q     <= MODE_W'(LOG_WAYS);
      last_vld_q <= 1'b0;
      rsp_vld_q  <= 1'b0;
      rsp_hit_q  <= 1'b0;
      tcnt_q     <= '0;
      dcnt_q     <= '0;
      for (int s = 0; s < SETS; s++) begin
        rr_q[s] <= '0;
      end
    end else begin
      state_q    <= state_d;
      mode_q     <= mode_d;
      last_vld_q <= last_vld_d;
      rsp_vld_q  <= rsp_vld_d;
      rsp_hit_q  <= rsp_hit_d;
      tcnt_q     <= tcnt_d;
      dcnt_q     <= dcnt_d;
      rr_q       <= rr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q   <= req_addr;
      wdata_q  <= req_wdata;
      victim_q <= victim;
      hitw_q   <= hit;
    end
    if (last_load) begin
      last_blk_q <= req_blk;
      last_way_q <= hit_way;
    end
    if (rsp_vld_d) begin
      rsp_dat_q <= rsp_dat_d;
    end
  end

  // ---------------- outputs ----------------
  assign resp_valid  = rsp_vld_q;
  assign resp_hit    = rsp_hit_q;
  assign resp_rdata  = rsp_dat_q;
  assign mem_valid   = ~idle;
  assign mem_write   = (state_q == ST_WTHRU);
  assign mem_addr    = (state_q == ST_REFILL) ? {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}} : addr_q;
  assign mem_wdata   = wdata_q;
  assign tag_en_cnt  = tcnt_q;
  assign data_en_cnt = dcnt_q;

  // ---------------- assertions ----------------
  // R5
  shortcut_no_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && shortcut) |-> (tag_en == '0) && ($countones(data_en) == 1) && hit);

  // R4
  active_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !shortcut) |-> ($countones(tag_en) == (1 << mode_q)) && (tag_en == data_en));

  // R3
  hit_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && hit) |=> resp_valid && resp_hit && !mem_valid);

  // R2
  refill_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REFILL && mem_ready) |=> resp_valid && !resp_hit && !mem_valid);

  // R7
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_addr) && $stable(mem_write));

  // R6
  miss_clears_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_hit) |-> !last_vld_q);

  // R9
  busy_cfg_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |=> $stable(mode_q));

  // R8
  victim_in_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && !hit) |-> grp_mask[victim]);

endmodule

// File: tb/test_cwc_cache.sv
`timescale 1ns/1ps
module test_cwc_cache;

  localparam int AW = 10;
  localparam int DW = 32;
  localparam int LW = 4;
  localparam int NW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_load;
  logic [1:0]    cfg_ways_log;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          req_ready, resp_valid, resp_hit;
  logic [DW-1:0] resp_rdata;
  logic          mem_valid, mem_write, mem_ready;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [LW*DW-1:0] mem_rline;
  logic [NW-1:0] tag_en, data_en;
  logic [31:0]   tag_en_cnt, data_en_cnt;

  always #10 clk = ~clk;

  cwc_cache i_cwc_cache (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_ways_log(cfg_ways_log),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .resp_valid(resp_valid),
    .resp_hit(resp_hit), .resp_rdata(resp_rdata), .mem_valid(mem_valid),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rline(mem_rline), .tag_en(tag_en),
    .data_en(data_en), .tag_en_cnt(tag_en_cnt), .data_en_cnt(data_en_cnt)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // ---------------- memory behind the cache ----------------
  logic [31:0] mainmem [1024];
  int n_rd = 0, n_wr = 0, mem_wait = 0;
  int last_wa = 0;
  logic [31:0] last_wd = '0;

  initial begin
    mem_ready = 1'b0;
    mem_rline = '0;
    for (int a = 0; a < 1024; a++) mainmem[a] = (a * 32'h00010203) ^ 32'h5A000000;
    forever begin
      @(negedge clk);
      if (mem_valid && !mem_ready) begin
        mem_wait++;
        if (mem_wait == 2) begin
          mem_wait  = 0;
          mem_ready = 1'b1;
          if (mem_write) begin
            mainmem[int'(mem_addr)] = mem_wdata;
            last_wa = int'(mem_addr);
            last_wd = mem_wdata;
            n_wr++;
          end else begin
            for (int w = 0; w < LW; w++) mem_rline[w*DW +: DW] = mainmem[int'(mem_addr) + w];
            n_rd++;
          end
        end
      end else begin
        mem_ready = 1'b0;
      end
    end
  end

  // ---------------- reference model ----------------
  bit          mv [4][4];
  int          mt [4][4];
  logic [31:0] md [4][4][4];
  int          mrr [4];
  bit          lv = 0;
  int          lblk = 0, lway = 0, m = 2;
  longint      tcnt = 0, dcnt = 0;

  function automatic int pc(input int v);
    int c = 0;
    for (int b = 0; b < 8; b++) if (v[b]) c++;
    return c;
  endfunction

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic model_inval();
    for (int p = 0; p < 4; p++) for (int s = 0; s < 4; s++) mv[p][s] = 0;
    for (int s = 0; s < 4; s++) mrr[s] = 0;
    lv = 0;
  endtask

  task automatic set_mode(input int v);
    @(negedge clk);
    cfg_load = 1'b1;
    cfg_ways_log = v[1:0];
    #1 chk("R9", "req_ready during cfg", req_ready, 0);
    @(negedge clk);
    cfg_load = 1'b0;
    m = (v > 2) ? 2 : v;
    model_inval();
  endtask

  task automatic do_acc(input bit wr, input int addr, input logic [31:0] wd,
                        input string rq, input bit busy);
    int blk, set, tag, ext, wm, base, gm, et, ed, way, v, rd0, wr0, k;
    bit hit, sc;
    logic [31:0] exp_d;
    blk = addr >> 2; set = (addr >> 2) & 3; tag = addr >> 4; ext = (addr >> 4) & 3;
    wm = (1 << m) - 1; base = (ext << m) & 3; gm = 0; way = 0; hit = 0; exp_d = '0;
    for (int p = 0; p < 4; p++) if (((p & ~wm) & 3) == base) gm |= (1 << p);
    sc = lv && (blk == lblk);
    if (sc) begin
      hit = 1; way = lway; et = 0; ed = 1 << lway;
    end else begin
      et = gm; ed = gm;
      for (int p = 0; p < 4; p++)
        if (gm[p] && mv[p][set] && mt[p][set] == tag) begin hit = 1; way = p; end
    end
    tcnt += pc(et); dcnt += pc(ed);
    if (!wr) begin
      if (hit) begin
        exp_d = md[way][set][addr & 3];
        lv = 1; lblk = blk; lway = way;
      end else begin
        v = base | (mrr[set] & wm);
        for (int w = 0; w < 4; w++) md[v][set][w] = mainmem[(addr & ~3) + w];
        mv[v][set] = 1; mt[v][set] = tag;
        mrr[set] = (v + 1) & wm;
        exp_d = mainmem[addr];
        lv = 0;
      end
    end else begin
      if (hit) begin
        md[way][set][addr & 3] = wd;
        lv = 1; lblk = blk; lway = way;
      end else begin
        lv = 0;
      end
    end
    rd0 = n_rd; wr0 = n_wr;

    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr[AW-1:0]; req_wdata = wd;
    #1;
    chk(rq, "req_ready", req_ready, 1);
    chk(rq, "tag_en", tag_en, et);
    chk(rq, "data_en", data_en, ed);
    @(negedge clk);
    req_valid = 1'b0;
    if (busy) begin cfg_load = 1'b1; cfg_ways_log = 2'd2; end
    k = 0;
    while (!resp_valid && k < 60) begin
      @(negedge clk);
      cfg_load = 1'b0;
      k++;
    end
    chk(rq, "resp_valid", resp_valid, 1);
    chk(rq, "resp_hit", resp_hit, hit);
    if (!wr) begin
      chk(rq, "resp_rdata", resp_rdata, exp_d);
      chk(rq, "memory reads", n_rd, rd0 + (hit ? 0 : 1));
      chk(rq, "memory writes", n_wr, wr0);
    end else begin
      chk("R7", "memory writes", n_wr, wr0 + 1);
      chk("R7", "write address", last_wa, addr);
      chk("R7", "write data", last_wd, wd);
    end
    chk("R10", "tag_en_cnt", tag_en_cnt, tcnt);
    chk("R10", "data_en_cnt", data_en_cnt, dcnt);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    rst_n = 1'b0; cfg_load = 1'b0; cfg_ways_log = 2'd0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    model_inval();
    repeat (3) @(negedge clk);
    chk("R1", "req_ready in reset", req_ready, 1);
    chk("R1", "resp_valid in reset", resp_valid, 0);
    chk("R1", "mem_valid in reset", mem_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "tag_en idle", tag_en, 0);
    chk("R1", "data_en idle", data_en, 0);
    chk("R1", "tag_en_cnt", tag_en_cnt, 0);
    chk("R1", "data_en_cnt", data_en_cnt, 0);
    chk("R1", "mem_valid", mem_valid, 0);

    // R2 miss then R3 hit through a full lookup, then R5 shortcut
    do_acc(0, 'h005, 0, "R2", 0);
    do_acc(0, 'h006, 0, "R3", 0);
    do_acc(0, 'h007, 0, "R5", 0);
    do_acc(0, 'h004, 0, "R5", 0);
    // R8 fill every way of set 1 and wrap the pointer
    do_acc(0, 'h014, 0, "R8", 0);
    do_acc(0, 'h024, 0, "R8", 0);
    do_acc(0, 'h034, 0, "R8", 0);
    do_acc(0, 'h044, 0, "R8", 0);
    do_acc(0, 'h005, 0, "R8", 0);
    do_acc(0, 'h014, 0, "R8", 0);
    do_acc(0, 'h015, 0, "R8", 0);
    do_acc(0, 'h016, 0, "R5", 0);
    // R7 write hit keeps shortcut, write miss does not allocate
    do_acc(0, 'h024, 0, "R7", 0);
    do_acc(1, 'h025, 32'hCAFE0001, "R7", 0);
    do_acc(0, 'h025, 0, "R7", 0);
    do_acc(1, 'h3A0, 32'hBEEF0002, "R7", 0);
    do_acc(0, 'h025, 0, "R6", 0);
    do_acc(0, 'h3A0, 0, "R7", 0);
    // R9 two-way mode, everything invalidated; R4 group selection
    set_mode(1);
    do_acc(0, 'h025, 0, "R9", 0);
    do_acc(0, 'h030, 0, "R4", 0);
    do_acc(0, 'h020, 0, "R4", 0);
    do_acc(0, 'h031, 0, "R4", 0);
    // R9 cfg pulse while a refill is pending is ignored
    do_acc(0, 'h0C0, 0, "R9", 1);
    do_acc(0, 'h0C1, 0, "R9", 0);
    // R11 direct-mapped: same base index, four groups coexist
    set_mode(0);
    do_acc(0, 'h008, 0, "R11", 0);
    do_acc(0, 'h018, 0, "R11", 0);
    do_acc(0, 'h028, 0, "R11", 0);
    do_acc(0, 'h038, 0, "R11", 0);
    do_acc(0, 'h009, 0, "R11", 0);
    do_acc(0, 'h019, 0, "R11", 0);
    do_acc(0, 'h029, 0, "R11", 0);
    do_acc(0, 'h039, 0, "R11", 0);
    do_acc(1, 'h02A, 32'h12340003, "R7", 0);
    do_acc(0, 'h02A, 0, "R5", 0);
    // R4 out-of-range value selects all ways
    set_mode(3);
    do_acc(0, 'h008, 0, "R4", 0);
    do_acc(0, 'h018, 0, "R4", 0);
    do_acc(0, 'h009, 0, "R4", 0);

    done = 1;
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule